// File: doc/BRIEF.md
# Symmetric Rounder with Saturation

This stage reduces a 19-bit two's complement sample to a 16-bit two's complement result. The input has a 16-bit integer part and 3 fractional bits. The result is rounded to the nearest integer. When the fraction is exactly one half, the result moves away from zero. Positive and negative inputs are therefore treated as mirror images, and the rounding adds no constant offset (no 0 Hz component) to the signal. Any rounded value beyond the 16-bit range is clamped to the nearest limit, so it never wraps to the opposite sign.

Samples enter and leave on valid/ready streams. A sample is accepted on a clock edge where `in_valid` and `in_ready` are both high. It is handed off on an edge where `out_valid` and `out_ready` are both high. A single output register holds the rounded value, which gives one cycle of latency. Back-pressure passes straight through: `in_ready` is high exactly when the output register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the output register holds its sample and no new sample is accepted.

Top module: `sym_rounder`

## Requirements
- R1: For a non-negative input, a fraction below one half (fraction field 0 to 3) truncates, and a fraction of one half or more (fraction field 4 to 7) adds one to the integer part.
- R2: For a negative input, the result is the negated rounding of its magnitude. A fraction of exactly one half moves the result away from zero, for example -2.5 gives -3 and -2.375 gives -2.
- R3: The stage is symmetric about zero. For every input x whose result is not clamped, the result for -x is the negation of the result for x.
- R4: Input codes 0x3FFFC through 0x3FFFF (values of 32767.5 and above) produce 32767 (0x7FFF) and never a negative value.
- R5: The most negative input code 0x40000 (-32768.0) produces -32768 (0x8000). No negative input produces a positive result.
- R6: A sample accepted on a clock edge appears on `out_data` with `out_valid` high after that same edge, which is one cycle of latency.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R8: `in_ready` equals `!out_valid || out_ready` in every cycle.
- R9: When reset is active (`rst_n` low, asynchronous), `out_valid` goes low. After release, the stage is empty and ready.
- R10: Every accepted sample leaves the stage exactly once, in order. None is dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Stage can accept a sample this cycle |
| in_data | input | 19 | Two's complement sample, 3 fractional bits |
| out_valid | output | 1 | Output register holds a rounded sample |
| out_ready | input | 1 | Downstream takes the sample this cycle |
| out_data | output | 16 | Rounded and clamped two's complement result |

## Verification
Assertions check the stream rules on every cycle: output is held stable under back-pressure, `in_ready` follows `out_valid` and `out_ready`, and an accepted sample becomes valid on the next edge. Inside the rounding logic, assertions also check that the result's sign never flips and that the top input codes clamp to the positive limit. The bench's scenarios cover the remaining behaviour. These are the exact rounding value of each code, mirror symmetry across pairs of opposite inputs, and in-order delivery of every beat when random stalls occur on both sides. Codes near zero and both range extremes are swept in full, and random codes fill the middle of the range.

// File: rtl/sym_rnd_pkg.sv
package sym_rnd_pkg;
  localparam int unsigned IN_W   = 19;
  localparam int unsigned FRAC_W = 3;
  localparam int unsigned OUT_W  = 16;
endpackage

// File: rtl/sym_rnd_core.sv
module sym_rnd_core #(
  parameter int unsigned IN_W   = 19,
  parameter int unsigned FRAC_W = 3,
  parameter int unsigned OUT_W  = 16
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int unsigned EXT_W = IN_W + 1;
  localparam int unsigned QW    = EXT_W - FRAC_W;

  logic signed [QW-1:0] q;

  generate
    if (FRAC_W == 0) begin : g_nofrac
      assign q = $signed({din[IN_W-1], din});
    end else begin : g_round
      localparam logic signed [EXT_W-1:0] HALF = EXT_W'(1) << (FRAC_W - 1);
      logic signed [EXT_W-1:0] ext, biased;
      logic                    neg;
      always_comb begin
        ext    = $signed({din[IN_W-1], din});
        neg    = din[IN_W-1];
        // half away from zero: negative values take one less of bias
        biased = ext + HALF - EXT_W'(neg);
      end
      assign q = biased[EXT_W-1:FRAC_W];
    end

    if (QW > OUT_W) begin : g_sat
      localparam logic signed [QW-1:0] QMAX = QW'({1'b0, {(OUT_W-1){1'b1}}});
      localparam logic signed [QW-1:0] QMIN = ~QMAX;
      always_comb begin
        if (q > QMAX)      dout = {1'b0, {(OUT_W-1){1'b1}}};
        else if (q < QMIN) dout = {1'b1, {(OUT_W-1){1'b0}}};
        else               dout = q[OUT_W-1:0];
      end
    end else begin : g_ext
      assign dout = OUT_W'(q);
    end
  endgenerate

  localparam logic [IN_W-1:0] TOP_START =
    {1'b0, {(IN_W-1){1'b1}}} - IN_W'((FRAC_W > 0) ? ((1 << (FRAC_W-1)) - 1) : 0);

  always_comb begin
    if (!$isunknown(din)) begin
      // R5: sign never flips through rounding or clamping
      a_r5_no_wrap: assert (dout == '0 || dout[OUT_W-1] == din[IN_W-1]);
      // R4: topmost codes clamp to the positive limit
      if (!din[IN_W-1] && din >= TOP_START && QW > OUT_W)
        a_r4_pos_clamp: assert (dout == {1'b0, {(OUT_W-1){1'b1}}});
    end
  end
endmodule

// File: rtl/sym_rnd_stage.sv
module sym_rnd_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;
  logic         take;

  assign up_ready = !vld_q || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                vld_q <= 1'b0;
    else if (up_ready)         vld_q <= up_valid;
  end

  always_ff @(posedge clk) begin
    if (take) dat_q <= up_data;
  end

  assign dn_valid = vld_q;
  assign dn_data  = dat_q;

  // R7: held beat stays put
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));
  // R6: accepted beat is valid on the next edge
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready |=> dn_valid);
  // R8: ready follows the output register
  a_r8_ready: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready == (!dn_valid || dn_ready));
  // R10: an emptied register with no new beat is empty next
  a_r10_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_ready && !up_valid |=> !dn_valid);
endmodule

// File: rtl/sym_rounder.sv
module sym_rounder
  import sym_rnd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  logic [OUT_W-1:0] rounded;

  sym_rnd_core #(.IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_core (
    .din  (in_data),
    .dout (rounded)
  );

  sym_rnd_stage #(.W(OUT_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (rounded),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data)
  );

  // R9: reset empties the stage
  a_r9_reset_empty: assert property (@(posedge clk)
    !rst_n |-> !out_valid);
endmodule

// File: tb/tb_sym_rounder.sv
module tb_sym_rounder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;
  localparam int N_RAND     = 40000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [18:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sym_rounder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic int ref_round(input logic [18:0] code);
    int v, r;
    v = int'($signed(code));
    if (v >= 0) r = (v + 4) / 8;
    else        r = -((-v + 4) / 8);
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic string tag_of(input logic [18:0] code);
    int v;
    v = int'($signed(code));
    if (v >= 262140)  return "R4";
    if (v <= -262140) return "R5";
    if (v < 0)        return "R2";
    return "R1";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [18:0] codes[$];
    logic [18:0] sentq[$];
    int          got[int];
    int          idx, received;
    bit          accepted, hold_pend, lat_pend;
    logic [15:0] hold_data;

    void'($urandom(32'h1357_2468));
    for (int v = -64; v <= 64; v++) codes.push_back(19'(v));
    for (int v = 262080; v <= 262143; v++) codes.push_back(19'(v));
    for (int v = -262144; v <= -262080; v++) codes.push_back(19'(v));
    for (int i = 0; i < N_RAND; i++) codes.push_back(19'($urandom));

    repeat (3) @(negedge clk);
    // R9: empty and ready while and after reset
    check("R9", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", int'(out_valid), 0);
    check("R9", int'(in_ready), 1);

    idx = 0; received = 0; accepted = 1; hold_pend = 0; lat_pend = 0;
    while (received < codes.size()) begin
      @(negedge clk);
      if (hold_pend) begin
        check("R7", int'(out_valid), 1);
        check("R7", int'(out_data), int'(hold_data));
      end
      if (lat_pend) check("R6", int'(out_valid), 1);

      if (!in_valid || accepted) begin
        if (idx < codes.size() && ($urandom % 4) != 0) begin
          in_valid = 1'b1;
          in_data  = codes[idx];
          idx++;
        end else begin
          in_valid = 1'b0;
        end
      end
      out_ready = (($urandom % 4) != 0);
      #1;
      check("R8", int'(in_ready), int'(!out_valid || out_ready));

      if (out_valid && out_ready) begin
        if (sentq.size() == 0) begin
          check("R10", 1, 0);
        end else begin
          logic [18:0] c;
          c = sentq.pop_front();
          check(tag_of(c), int'($signed(out_data)), ref_round(c));
          if (int'($signed(c)) >= -64 && int'($signed(c)) <= 64)
            got[int'($signed(c))] = int'($signed(out_data));
          received++;
        end
      end
      accepted = in_valid && in_ready;
      if (accepted) sentq.push_back(in_data);
      lat_pend  = accepted;
      hold_pend = out_valid && !out_ready;
      hold_data = out_data;
    end

    @(negedge clk);
    out_ready = 1'b1;
    in_valid  = 1'b0;
    @(negedge clk);
    // R10: nothing left over once every beat came back
    check("R10", int'(out_valid), 0);
    check("R10", sentq.size(), 0);

    // R3: mirror pairs near zero
    for (int v = 1; v <= 64; v++) begin
      if (got.exists(v) && got.exists(-v)) check("R3", got[-v], -got[v]);
      else check("R3", 0, 1);
    end
    // R1, R2: directed half-way points
    if (got.exists(20)) check("R1", got[20], 3);
    if (got.exists(19)) check("R1", got[19], 2);
    if (got.exists(-20)) check("R2", got[-20], -3);
    if (got.exists(-19)) check("R2", got[-19], -2);

    done = 1;
    finish_run();
  end
endmodule